// File: doc/BRIEF.md
# Flash Row Program-Stress Guard

This block sits in front of the programming sequencer of a small flash array organised in rows of 32 sixteen-bit words (64 bytes). Each program of a byte or a word raises high voltage across the whole row that holds it. The cells tolerate only a limited amount of that stress between two erases, and a given word may be programmed at most twice before its row is erased again. The guard keeps a running count of stress for each row and a program-operation count for each word, and it either grants or refuses every program request before the request reaches the sequencer.

Stress is measured in ticks of the high-voltage generator clock. The sequencer raises a tick strobe, tagged with the row being programmed, for every generator cycle that the high voltage is applied. The budget is a parameter derived from the allowed cumulative time and the generator frequency (10 ms at 257 kHz gives 2570 ticks by default). One write costs 29 ticks by default. With these values the budget admits 88 full writes to a row; at 476 kHz it would admit about 164. A request is refused if the row's count plus the cost of one more write would go past the budget. It is also refused if its word has already been programmed twice. The budget test takes precedence. Erasing a row clears both its stress count and all of its word counts.

A response is a one-cycle pulse on the cycle after the request, carrying either a grant or a reject together with a reason code. Byte and word programs are treated alike, so requests carry no size.

Top module: `flash_stress_guard`

## Requirements
- R1: During and right after synchronous reset, grant and reject are low and reason is 0. All row stress counts and word counts start at zero, so the first request to any word of any row is granted.
- R2: A request (req_valid high at a clock edge) produces exactly one response pulse on the next cycle. A grant has reason 0, and grant and reject are never high together. No response appears in a cycle that follows no request.
- R3: A byte program counts as one operation on its word, exactly like a full word program. After two granted operations on a word since its row's last erase, a further request to that word is rejected with reason 2 (word limit). Other words of the row are unaffected.
- R4: A request is rejected with reason 1 (row budget) when the row's tick count plus TICKS_PER_WRITE exceeds BUDGET_TICKS. A count of exactly BUDGET_TICKS minus TICKS_PER_WRITE is still granted. When both limits apply, reason 1 is reported.
- R5: A high-voltage tick adds one to the stress count of the row named by hv_row only. Other rows keep their budgets.
- R6: An erase clears the stress count and all 32 word counts of the named row, and leaves every other row unchanged.
- R7: A request in the same cycle as an erase of its own row is judged on the state before the erase, and the erase wins the state update, so the word count is zero afterwards.
- R8: A row's stress count saturates at BUDGET_TICKS and never wraps back into the granting range, however many further ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Program request strobe |
| req_row | input | ROW_W | Row of the requested program |
| req_word | input | 5 | Word index within the row |
| hv_tick | input | 1 | One high-voltage generator cycle applied |
| hv_row | input | ROW_W | Row receiving the high-voltage tick |
| erase_valid | input | 1 | Row erase strobe |
| erase_row | input | ROW_W | Row being erased |
| grant | output | 1 | Request permitted (one-cycle pulse) |
| reject | output | 1 | Request refused (one-cycle pulse) |
| reason | output | 2 | 0 none, 1 row budget exhausted, 2 word limit reached |

## Verification
A stress counter that is wrong by even one tick shows up at the budget boundary. There, the request that must still pass at exactly the budget minus one write's cost, or the request that must fail one tick later, flips its grant one cycle after it is issued. A corrupt word count appears no later than the third request to that word, as a wrong grant or a wrong reason. State leaking between rows, an erase that misses or overreaches, and a counter that wraps all become visible as grants on rows that should refuse, or refusals on rows that should grant. The bench drives each of these rows to its limits and probes neighbouring rows and words to expose them.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int WORDS_PER_ROW     = 32;
    localparam int WORD_IDX_W        = $clog2(WORDS_PER_ROW);
    localparam int MAX_PROG_PER_WORD = 2;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_BUDGET = 2'd1,
        RSN_WORD   = 2'd2
    } reason_e;

    typedef struct packed {
        logic    grant;
        logic    reject;
        reason_e reason;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{grant: 1'b0, reject: 1'b0, reason: RSN_NONE};

    // Budget test outranks the word limit.
    function automatic verdict_t judge(input logic over_budget, input logic word_full);
        verdict_t v;
        v = VERDICT_IDLE;
        if (over_budget) begin
            v.reject = 1'b1;
            v.reason = RSN_BUDGET;
        end else if (word_full) begin
            v.reject = 1'b1;
            v.reason = RSN_WORD;
        end else begin
            v.grant  = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/fsg_row_stress.sv
module fsg_row_stress #(
    parameter int BUDGET_TICKS = 2570,
    parameter int CNT_W        = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(BUDGET_TICKS);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (tick && (count < CAP)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fsg_word_tally.sv
module fsg_word_tally
    import fsg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  inc,
    input  logic [WORD_IDX_W-1:0] word,
    output logic                  full
);
    logic [1:0] tally [WORDS_PER_ROW];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS_PER_ROW; i++) begin
            if (rst || clr) begin
                tally[i] <= 2'd0;
            end else if (inc && (word == WORD_IDX_W'(i)) && (tally[i] < 2'(MAX_PROG_PER_WORD))) begin
                tally[i] <= tally[i] + 2'd1;
            end
        end
    end

    assign full = (tally[word] >= 2'(MAX_PROG_PER_WORD));
endmodule

// File: rtl/flash_stress_guard.sv
module flash_stress_guard
    import fsg_pkg::*;
#(
    parameter int ROWS            = 4,
    parameter int GEN_KHZ         = 257,
    parameter int BUDGET_US       = 10000,
    parameter int TICKS_PER_WRITE = 29,
    localparam int ROW_W          = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [ROW_W-1:0]      req_row,
    input  logic [WORD_IDX_W-1:0] req_word,
    input  logic                  hv_tick,
    input  logic [ROW_W-1:0]      hv_row,
    input  logic                  erase_valid,
    input  logic [ROW_W-1:0]      erase_row,
    output logic                  grant,
    output logic                  reject,
    output logic [1:0]            reason
);
    localparam int BUDGET_TICKS = (GEN_KHZ * BUDGET_US) / 1000;
    localparam int CNT_W        = $clog2(BUDGET_TICKS + 1);
    localparam int SUM_W        = CNT_W + 1;

    logic [CNT_W-1:0] stress [ROWS];
    logic [ROWS-1:0]  word_full;
    logic [ROWS-1:0]  row_clr;
    logic [ROWS-1:0]  row_inc;
    verdict_t         now_v;
    verdict_t         resp_q;
    logic [SUM_W-1:0] projected;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_clr[r] = erase_valid && (erase_row == ROW_W'(r));
        assign row_inc[r] = req_valid && now_v.grant && (req_row == ROW_W'(r));

        fsg_row_stress #(
            .BUDGET_TICKS(BUDGET_TICKS),
            .CNT_W       (CNT_W)
        ) u_stress (
            .clk  (clk),
            .rst  (rst),
            .clr  (row_clr[r]),
            .tick (hv_tick && (hv_row == ROW_W'(r))),
            .count(stress[r])
        );

        fsg_word_tally u_tally (
            .clk (clk),
            .rst (rst),
            .clr (row_clr[r]),
            .inc (row_inc[r]),
            .word(req_word),
            .full(word_full[r])
        );
    end

    assign projected = SUM_W'(stress[req_row]) + SUM_W'(TICKS_PER_WRITE);
    assign now_v     = judge(projected > SUM_W'(BUDGET_TICKS), word_full[req_row]);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= VERDICT_IDLE;
        end else if (req_valid) begin
            resp_q <= now_v;
        end else begin
            resp_q <= VERDICT_IDLE;
        end
    end

    assign grant  = resp_q.grant;
    assign reject = resp_q.reject;
    assign reason = resp_q.reason;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       grant,
    input logic       reject,
    input logic [1:0] reason
);
    // R1: outputs idle in the cycle after reset is sampled
    p_idle_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!grant && !reject && reason == 2'd0));

    // R2: grant and reject are exclusive
    p_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(grant && reject));

    // R2: a response follows only a request
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid) |-> (!grant && !reject));

    // R2: a request always gets a response
    p_always_answered_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !$past(rst)) |=> (grant || reject));

    // R2: grants carry reason 0
    p_grant_reason_r2: assert property (@(posedge clk) disable iff (rst)
        grant |-> (reason == 2'd0));

    // R3 / R4: rejects carry reason 1 or 2
    p_reject_reason_r4: assert property (@(posedge clk) disable iff (rst)
        reject |-> (reason == 2'd1 || reason == 2'd2));
endmodule

bind flash_stress_guard fsg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .grant    (grant),
    .reject   (reject),
    .reason   (reason)
);

// File: tb/flash_stress_guard_tb.sv
module flash_stress_guard_tb;
    localparam int TPW    = 29;
    localparam int BUDGET = 2570;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_row = '0;
    logic [4:0] req_word = '0;
    logic       hv_tick = 1'b0;
    logic [1:0] hv_row = '0;
    logic       erase_valid = 1'b0;
    logic [1:0] erase_row = '0;
    logic       grant, reject;
    logic [1:0] reason;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_stress_guard u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_row(req_row), .req_word(req_word),
        .hv_tick(hv_tick), .hv_row(hv_row),
        .erase_valid(erase_valid), .erase_row(erase_row),
        .grant(grant), .reject(reject), .reason(reason)
    );

    task automatic check(input string tag, input logic g, input logic j, input logic [1:0] rs,
                         input logic eg, input logic ej, input logic [1:0] ers);
        checks++;
        if (g !== eg || j !== ej || rs !== ers) begin
            errors++;
            $display("FAIL %s: got grant=%0b reject=%0b reason=%0d, expected grant=%0b reject=%0b reason=%0d",
                     tag, g, j, rs, eg, ej, ers);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic do_req(input string tag, input logic [1:0] row, input logic [4:0] word,
                          input logic exp_g, input logic [1:0] exp_rs);
        @(negedge clk);
        req_valid = 1'b1; req_row = row; req_word = word;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, grant, reject, reason, exp_g, !exp_g, exp_rs);
    endtask

    task automatic ticks(input logic [1:0] row, input int n);
        @(negedge clk);
        hv_row = row;
        for (int i = 0; i < n; i++) begin
            hv_tick = 1'b1;
            @(negedge clk);
        end
        hv_tick = 1'b0;
    endtask

    task automatic erase(input logic [1:0] row);
        @(negedge clk);
        erase_valid = 1'b1; erase_row = row;
        @(negedge clk);
        erase_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 idle after reset", grant, reject, reason, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        check("R2 no response without request", grant, reject, reason, 1'b0, 1'b0, 2'd0);
        do_req("R1 fresh row3 word31", 2'd3, 5'd31, 1'b1, 2'd0);
    endtask

    task automatic t_word_limit();
        do_req("R3 first op word3", 2'd0, 5'd3, 1'b1, 2'd0);
        do_req("R3 second op (byte) word3", 2'd0, 5'd3, 1'b1, 2'd0);
        do_req("R3 third op word3", 2'd0, 5'd3, 1'b0, 2'd2);
        do_req("R3 neighbour word4", 2'd0, 5'd4, 1'b1, 2'd0);
    endtask

    task automatic t_budget();
        do_req("R4 word5 op1", 2'd1, 5'd5, 1'b1, 2'd0);
        do_req("R4 word5 op2", 2'd1, 5'd5, 1'b1, 2'd0);
        ticks(2'd1, BUDGET - TPW);
        do_req("R4 at exact boundary", 2'd1, 5'd6, 1'b1, 2'd0);
        ticks(2'd1, 1);
        do_req("R4 one tick over", 2'd1, 5'd7, 1'b0, 2'd1);
        do_req("R4 budget outranks word limit", 2'd1, 5'd5, 1'b0, 2'd1);
        do_req("R5 row2 unaffected by row1 ticks", 2'd2, 5'd5, 1'b1, 2'd0);
    endtask

    task automatic t_saturate();
        ticks(2'd1, 1600);
        do_req("R8 no wrap after 4142 ticks", 2'd1, 5'd8, 1'b0, 2'd1);
    endtask

    task automatic t_erase();
        erase(2'd1);
        do_req("R6 erased row1 word5 granted", 2'd1, 5'd5, 1'b1, 2'd0);
        do_req("R6 row0 word3 still full", 2'd0, 5'd3, 1'b0, 2'd2);
    endtask

    task automatic t_erase_same_cycle();
        @(negedge clk);
        req_valid = 1'b1; req_row = 2'd0; req_word = 5'd3;
        erase_valid = 1'b1; erase_row = 2'd0;
        @(negedge clk);
        req_valid = 1'b0; erase_valid = 1'b0;
        check("R7 judged on pre-erase state", grant, reject, reason, 1'b0, 1'b1, 2'd2);
        do_req("R7 erase wins, op1", 2'd0, 5'd3, 1'b1, 2'd0);
        do_req("R7 erase wins, op2", 2'd0, 5'd3, 1'b1, 2'd0);
        // grant in the same cycle as erase must not be counted
        @(negedge clk);
        req_valid = 1'b1; req_row = 2'd2; req_word = 5'd9;
        erase_valid = 1'b1; erase_row = 2'd2;
        @(negedge clk);
        req_valid = 1'b0; erase_valid = 1'b0;
        check("R7 grant alongside erase", grant, reject, reason, 1'b1, 1'b0, 2'd0);
        do_req("R7 word9 op after erase 1", 2'd2, 5'd9, 1'b1, 2'd0);
        do_req("R7 word9 op after erase 2", 2'd2, 5'd9, 1'b1, 2'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_word_limit();
                t_budget();
                t_saturate();
                t_erase();
                t_erase_same_cycle();
            end
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule